// File: doc/BRIEF.md
# Latched Interrupt Request Register

This block gathers interrupt requests for a small soft processor. Five request lines come in: four push-button lines and one read-request line from a host link. Each line passes through a synchronizer and a rising-edge detector. A detected edge sets a sticky status bit for that source. The bits stay set until the processor pulses its interrupt-acknowledge input, and that pulse clears all of them together. The single interrupt output is high whenever any captured bit is set.

The processor finds out which source fired by reading the captured bits as an 8-bit status word on its input port. Because capture works on edges, a button that is held down raises one request, not a stream of them. A request that arrives in the same cycle as an acknowledge survives the clear.

Top module: `irq_capture_top`

## Requirements
- R1: `status_o` bit k (k = 0..3) holds the capture for `btn_i[k]`, bit 4 holds the capture for `host_rd_req_i`, and bits 7..5 always read as zero.
- R2: A rising edge on a request input sets its status bit. The bit is visible on `status_o` after the third rising clock edge that follows the input change: two synchronizer stages and then the capture register.
- R3: Once set, a status bit stays set when its input returns low, for as long as no acknowledge arrives.
- R4: When `int_ack_i` is high at a clock edge, every status bit clears at that edge, unless a new edge is being captured at that same edge.
- R5: If a new rising edge is captured at the same clock edge at which `int_ack_i` is high, that source's bit ends up set, while the other bits clear.
- R6: An input held high sets its bit only once. After an acknowledge, the bit stays clear while the input remains high.
- R7: `irq_o` is high exactly when at least one status bit is set.
- R8: A synchronous active-high `rst` clears every status bit and drives `irq_o` low at the next clock edge.
- R9: Requests that rise together on several inputs are captured together, each in its own bit, for every combination of the five sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_i | input | 4 | Push-button request lines, asynchronous |
| host_rd_req_i | input | 1 | Host-link read-request line, asynchronous |
| int_ack_i | input | 1 | Interrupt acknowledge from the processor; clears the captured bits |
| irq_o | output | 1 | Interrupt request to the processor |
| status_o | output | 8 | Captured request bits for readback |

## Verification
The hardest case to reach is a fresh edge that reaches the capture register in the same cycle as an acknowledge. The synchronizer hides the input from the port, so the stimulus has to count edges. It first leaves one source captured. It then raises a second input, waits two clock edges so that the edge sits at the end of the synchronizer, and raises the acknowledge for exactly the next edge. Afterwards the first bit must be clear and the second bit must be set. All 31 non-empty source combinations are swept through set, hold, acknowledge and release, and each step's expected word is computed from the input mask.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

    // Number of push-button request lines
    localparam int unsigned BTN_COUNT   = 4;
    // Total request sources: buttons plus one host read-request
    localparam int unsigned SRC_COUNT   = BTN_COUNT + 1;
    // Width of the processor input port
    localparam int unsigned PORT_WIDTH  = 8;

    // Build the raw source vector: buttons in the low bits, host request above
    function automatic logic [SRC_COUNT-1:0] gather_src(
        input logic [BTN_COUNT-1:0] btn,
        input logic                 host_req
    );
        return {host_req, btn};
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous request lines
module irq_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d          = st_q;
                st_d.chain[0] = async_i;
            end
        end else begin : g_multi
            always_comb begin
                st_d = st_q;
                st_d.chain[0] = async_i;
                for (int s = 1; s < int'(STAGES); s++) begin
                    st_d.chain[s] = st_q.chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/irq_edge.sv
// Rising-edge detector on a synchronized level vector
module irq_edge #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [WIDTH-1:0] rise_d;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise_d    = level_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = rise_d;

endmodule

// File: rtl/irq_sticky.sv
// Sticky capture bits: set by edge pulses, cleared together by acknowledge.
// A set that coincides with the clear takes priority.
module irq_sticky #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clear_i,
    output logic [WIDTH-1:0] bits_o
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } sticky_state_t;

    sticky_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.bits = '0;
        end
        st_d.bits = st_d.bits | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;

endmodule

// File: rtl/irq_capture_top.sv
module irq_capture_top
    import irq_cap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BTN_COUNT-1:0]  btn_i,
    input  logic                  host_rd_req_i,
    input  logic                  int_ack_i,
    output logic                  irq_o,
    output logic [PORT_WIDTH-1:0] status_o
);

    localparam int unsigned PAD_W = PORT_WIDTH - SRC_COUNT;

    logic [SRC_COUNT-1:0] raw_src;
    logic [SRC_COUNT-1:0] sync_src;
    logic [SRC_COUNT-1:0] rise_src;
    logic [SRC_COUNT-1:0] held_src;

    assign raw_src = gather_src(btn_i, host_rd_req_i);

    irq_sync #(
        .WIDTH  (SRC_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_src),
        .sync_o  (sync_src)
    );

    irq_edge #(
        .WIDTH (SRC_COUNT)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (sync_src),
        .rise_o  (rise_src)
    );

    irq_sticky #(
        .WIDTH (SRC_COUNT)
    ) u_sticky (
        .clk     (clk),
        .rst     (rst),
        .set_i   (rise_src),
        .clear_i (int_ack_i),
        .bits_o  (held_src)
    );

    assign irq_o    = |held_src;
    assign status_o = {{PAD_W{1'b0}}, held_src};

endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk
    import irq_cap_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [BTN_COUNT-1:0]  btn_i,
    input logic                  host_rd_req_i,
    input logic                  int_ack_i,
    input logic                  irq_o,
    input logic [PORT_WIDTH-1:0] status_o
);

    logic [SRC_COUNT-1:0] src;
    logic [1:0]           since_rst_q;

    assign src = {host_rd_req_i, btn_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst_q <= 2'd0;
        end else if (since_rst_q != 2'd3) begin
            since_rst_q <= since_rst_q + 2'd1;
        end
    end

    // R1
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[PORT_WIDTH-1:SRC_COUNT] == '0);

    // R7
    irq_or_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (status_o != '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !int_ack_i |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (int_ack_i && since_rst_q >= 2'd2 && $past(src, 2) == '0) |=> status_o == '0);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (status_o == '0 && !irq_o));

endmodule

bind irq_capture_top irq_capture_chk u_irq_capture_chk (
    .clk           (clk),
    .rst           (rst),
    .btn_i         (btn_i),
    .host_rd_req_i (host_rd_req_i),
    .int_ack_i     (int_ack_i),
    .irq_o         (irq_o),
    .status_o      (status_o)
);

// File: tb/test_irq_capture_top.sv
module test_irq_capture_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] btn = '0;
    logic       host_req = 1'b0;
    logic       ack = 1'b0;
    logic       irq;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_capture_top i_irq_capture_top (
        .clk           (clk),
        .rst           (rst),
        .btn_i         (btn),
        .host_rd_req_i (host_req),
        .int_ack_i     (ack),
        .irq_o         (irq),
        .status_o      (status)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] m);
        btn      = m[3:0];
        host_req = m[4];
    endtask

    task automatic pulse_ack;
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(4);
        // R8: state under reset
        chk("R8 reset status", status, 8'h00);
        chk("R8 reset irq", {7'd0, irq}, 8'h00);
        rst = 1'b0;
        tick(2);

        // R1 R2 R4 R6 R7 R9: sweep every non-empty source combination
        for (int m = 1; m < 32; m++) begin
            drive(m[4:0]);
            tick(2);
            chk("R2 not yet visible", status, 8'h00);
            tick(1);
            chk("R9 R1 captured mask", status, {3'b000, m[4:0]});
            chk("R7 irq set", {7'd0, irq}, 8'h01);
            tick(4);
            chk("R6 held keeps mask", status, {3'b000, m[4:0]});
            pulse_ack();
            chk("R4 ack clears", status, 8'h00);
            chk("R7 irq clear", {7'd0, irq}, 8'h00);
            tick(4);
            chk("R6 held does not re-set", status, 8'h00);
            drive(5'd0);
            tick(4);
            chk("R6 release no set", status, 8'h00);
        end

        // R3: single-cycle pulse on each source is kept long after release
        for (int k = 0; k < 5; k++) begin
            drive(5'(1 << k));
            tick(1);
            drive(5'd0);
            tick(12);
            chk("R3 pulse kept", status, 8'(1 << k));
            chk("R7 pulse irq", {7'd0, irq}, 8'h01);
            pulse_ack();
            chk("R4 pulse cleared", status, 8'h00);
            tick(3);
        end

        // R5: new edge on button 1 meets the acknowledge; button 0 was pending
        drive(5'b00001);
        tick(1);
        drive(5'b00000);
        tick(5);
        chk("R5 setup", status, 8'h01);
        drive(5'b00010);
        tick(2);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        chk("R5 set wins over ack", status, 8'h02);
        tick(3);
        chk("R5 bit stays", status, 8'h02);
        drive(5'd0);
        pulse_ack();
        chk("R4 final clear", status, 8'h00);

        // R8: reset in the middle of operation
        drive(5'b10100);
        tick(4);
        chk("R8 pre-reset", status, 8'h14);
        rst = 1'b1;
        tick(1);
        chk("R8 mid reset status", status, 8'h00);
        chk("R8 mid reset irq", {7'd0, irq}, 8'h00);
        drive(5'd0);
        tick(2);
        rst = 1'b0;
        tick(4);
        chk("R8 after reset idle", status, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule